// File: doc/BRIEF.md
# Bufferless Router Eject/Inject Stage

This block is the front pipeline stage of a deflection router that has no flit buffers. Every cycle a fixed set of internal channels arrives from the neighbouring links. Each channel either is empty or holds one flit. The stage takes out at most one flit whose destination field equals the tile's own address and places it on the single ejection port. It then offers the local core one injection slot into whichever channel is empty after that ejection. The updated channels, the ejected flit and the registered results go on to the port allocation stage that follows.

If several channels hold flits for the local tile, a flit carrying the golden (livelock-breaking) mark is taken first. With no golden candidate, the lowest-numbered candidate is taken. The remaining local flits stay where they are and are deflected downstream. Injection uses a valid/ready handshake. Ready is a same-cycle combinational function of the incoming channels. The core must hold its flit for as long as ready stays low.

Top module: `eject_inject_stage`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, all outputs are cleared on the clock edge: channel valids, the eject valid, and their flit fields.
- R2: A flit is `1+ADDR_W+DATA_W` bits. Bit `FLIT_W-1` is the golden mark, bits `[ADDR_W+DATA_W-1:DATA_W]` hold the destination, and the low `DATA_W` bits hold the payload. Channel i sits at bits `[i*FLIT_W +: FLIT_W]`. A valid flit whose destination equals `local_addr` is a local candidate.
- R3: At most one flit is ejected per cycle. When one or more local candidates carry the golden mark, the lowest-numbered golden candidate is ejected.
- R4: With no golden candidate, the lowest-numbered local candidate is ejected. Every other local candidate stays in its own channel, unchanged.
- R5: A flit that is not ejected appears one cycle later in the same channel with identical contents.
- R6: `inj_ready` is high in the same cycle exactly when at least one channel is empty after ejection. That is, it is low only when all channels are valid and none is ejected.
- R7: When `inj_valid` and `inj_ready` are both high, the injected flit enters the lowest-numbered channel that is empty after ejection. This includes a channel that was emptied by ejection in the same cycle. The injected flit is not itself ejected in that cycle.
- R8: When `inj_valid` or `inj_ready` is low, the injection flit has no effect on any output.
- R9: All outputs are registered. The eject port and the channel outputs show the result one clock edge after the inputs are presented. `ej_valid` is low when no local candidate existed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| local_addr | input | ADDR_W | Address of the local tile |
| ch_in_valid | input | NCH | Occupancy of each incoming channel |
| ch_in_flit | input | NCH*FLIT_W | Incoming channel flits, channel 0 in the low bits |
| inj_valid | input | 1 | Local core offers a flit |
| inj_flit | input | FLIT_W | Flit offered by the local core |
| inj_ready | output | 1 | Offered flit is accepted this cycle |
| ch_out_valid | output | NCH | Registered channel occupancy after eject and inject |
| ch_out_flit | output | NCH*FLIT_W | Registered channel flits |
| ej_valid | output | 1 | Registered: a flit was ejected |
| ej_flit | output | FLIT_W | Registered ejected flit |

## Verification
The bench builds the block with its defaults: four channels, a 3-bit address and an 8-bit payload. At this size every combination can be covered. It sweeps all occupancy patterns, all subsets of local candidates and all golden patterns, with injection both offered and withheld. That is 8192 cases, and the tile address rotates through all eight values. This covers multiple competing local flits, golden priority, a full set of channels with and without an ejection, and injection into a freed slot.

// File: rtl/ejinj_pkg.sv
package ejinj_pkg;
  // Default geometry shared by stage and bench
  localparam int DEF_NCH    = 4;
  localparam int DEF_ADDR_W = 3;
  localparam int DEF_DATA_W = 8;
endpackage

// File: rtl/ejinj_eject_pick.sv
module ejinj_eject_pick #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] cand,
  input  logic [NCH-1:0] gold,
  output logic [NCH-1:0] grant
);
  logic [NCH-1:0] gold_cand;
  logic [NCH-1:0] req;
  logic           seen;

  assign gold_cand = cand & gold;
  assign req       = (|gold_cand) ? gold_cand : cand;

  always_comb begin
    seen  = 1'b0;
    grant = '0;
    for (int i = 0; i < NCH; i++) begin
      grant[i] = req[i] & ~seen;
      seen     = seen | req[i];
    end
  end

  // R3
  golden_first_chk: assert property (@(posedge clk) disable iff (rst)
    (|gold_cand) |-> (|(grant & gold)));
  // R3
  single_eject_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && ((|cand) == (|grant)));
endmodule

// File: rtl/ejinj_inject_place.sv
module ejinj_inject_place #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] occupied,
  input  logic           req,
  output logic           ready,
  output logic [NCH-1:0] grant
);
  logic [NCH-1:0] free_ch;
  logic           seen;

  assign free_ch = ~occupied;
  assign ready   = |free_ch;

  always_comb begin
    seen  = 1'b0;
    grant = '0;
    for (int i = 0; i < NCH; i++) begin
      grant[i] = req & free_ch[i] & ~seen;
      seen     = seen | free_ch[i];
    end
  end

  // R7
  inject_free_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (grant & occupied) == '0);
endmodule

// File: rtl/eject_inject_stage.sv
module eject_inject_stage
  import ejinj_pkg::*;
#(
  parameter int NCH    = DEF_NCH,
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int DATA_W = DEF_DATA_W,
  localparam int FLIT_W = 1 + ADDR_W + DATA_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     local_addr,
  input  logic [NCH-1:0]        ch_in_valid,
  input  logic [NCH*FLIT_W-1:0] ch_in_flit,
  input  logic                  inj_valid,
  input  logic [FLIT_W-1:0]     inj_flit,
  output logic                  inj_ready,
  output logic [NCH-1:0]        ch_out_valid,
  output logic [NCH*FLIT_W-1:0] ch_out_flit,
  output logic                  ej_valid,
  output logic [FLIT_W-1:0]     ej_flit
);
  localparam int GOLD_BIT = FLIT_W - 1;

  logic [NCH-1:0]        cand, gold, ej_grant, remain, inj_grant;
  logic [NCH-1:0]        next_valid;
  logic [NCH*FLIT_W-1:0] next_flit;
  logic [FLIT_W-1:0]     ej_sel;

  for (genvar i = 0; i < NCH; i++) begin : g_field
    assign cand[i] = ch_in_valid[i] &&
      (ch_in_flit[i*FLIT_W+DATA_W +: ADDR_W] == local_addr);
    assign gold[i] = ch_in_flit[i*FLIT_W + GOLD_BIT];
    assign next_flit[i*FLIT_W +: FLIT_W] = inj_grant[i] ? inj_flit
                                         : ch_in_flit[i*FLIT_W +: FLIT_W];
  end

  ejinj_eject_pick #(.NCH(NCH)) u_pick (
    .clk(clk), .rst(rst), .cand(cand), .gold(gold), .grant(ej_grant)
  );

  assign remain = ch_in_valid & ~ej_grant;

  ejinj_inject_place #(.NCH(NCH)) u_place (
    .clk(clk), .rst(rst), .occupied(remain), .req(inj_valid),
    .ready(inj_ready), .grant(inj_grant)
  );

  assign next_valid = remain | inj_grant;

  always_comb begin
    ej_sel = '0;
    for (int i = 0; i < NCH; i++)
      ej_sel = ej_sel | ({FLIT_W{ej_grant[i]}} & ch_in_flit[i*FLIT_W +: FLIT_W]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_out_valid <= '0;
      ch_out_flit  <= '0;
      ej_valid     <= 1'b0;
      ej_flit      <= '0;
    end else begin
      ch_out_valid <= next_valid;
      ch_out_flit  <= next_flit;
      ej_valid     <= |ej_grant;
      ej_flit      <= ej_sel;
    end
  end

  // Marks cycles whose predecessor was out of reset
  logic live_q;
  always_ff @(posedge clk) live_q <= !rst;

  // R9
  flit_conserve_chk: assert property (@(posedge clk) disable iff (rst)
    live_q |-> ($countones(ch_out_valid) + 32'(ej_valid) ==
                $past($countones(ch_in_valid)) + 32'($past(inj_valid && inj_ready))));
  // R2
  eject_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (live_q && ej_valid) |-> (ej_flit[DATA_W +: ADDR_W] == $past(local_addr)));
  // R6
  ready_full_chk: assert property (@(posedge clk) disable iff (rst)
    !inj_ready |-> (&ch_in_valid));
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (ch_out_valid == '0 && !ej_valid));
endmodule

// File: tb/eject_inject_stage_tb.sv
module eject_inject_stage_tb;
  localparam int NCH = 4, AW = 3, DW = 8, FW = 1 + AW + DW;

  logic clk = 0, rst = 1;
  logic [AW-1:0] local_addr = '0;
  logic [NCH-1:0] ch_in_valid = '0;
  logic [NCH*FW-1:0] ch_in_flit = '0;
  logic inj_valid = 0;
  logic [FW-1:0] inj_flit = '0;
  logic inj_ready, ej_valid;
  logic [NCH-1:0] ch_out_valid;
  logic [NCH*FW-1:0] ch_out_flit;
  logic [FW-1:0] ej_flit;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  eject_inject_stage #(.NCH(NCH), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .local_addr(local_addr), .ch_in_valid(ch_in_valid),
    .ch_in_flit(ch_in_flit), .inj_valid(inj_valid), .inj_flit(inj_flit),
    .inj_ready(inj_ready), .ch_out_valid(ch_out_valid), .ch_out_flit(ch_out_flit),
    .ej_valid(ej_valid), .ej_flit(ej_flit)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_case(input int cnt, input logic [3:0] v, input logic [3:0] l,
                          input logic [3:0] g, input bit inj);
    logic [FW-1:0] f [NCH];
    logic [FW-1:0] exp_f [NCH];
    logic [3:0] loc, gl, req, sel, after, ins, exp_v;
    logic exp_rdy;
    logic [FW-1:0] exp_ej;
    local_addr = AW'(cnt % 8);
    for (int i = 0; i < NCH; i++) begin
      f[i] = {g[i], (l[i] ? local_addr : local_addr ^ AW'(i + 1)), DW'(i * 16 + cnt % 16)};
      ch_in_flit[i*FW +: FW] = f[i];
    end
    ch_in_valid = v;
    inj_valid = inj;
    inj_flit = {1'b0, local_addr, DW'(8'hA0 + cnt % 16)};
    // expected, from R2..R7
    loc = l & v;
    gl = loc & g;
    req = (gl != 0) ? gl : loc;
    sel = '0;
    for (int i = NCH - 1; i >= 0; i--) if (req[i]) sel = 4'(1 << i);
    after = v & ~sel;
    exp_rdy = (after != 4'hF);
    ins = '0;
    if (inj && exp_rdy)
      for (int i = NCH - 1; i >= 0; i--) if (!after[i]) ins = 4'(1 << i);
    exp_v = after | ins;
    exp_ej = '0;
    for (int i = 0; i < NCH; i++) begin
      exp_f[i] = ins[i] ? inj_flit : f[i];
      if (sel[i]) exp_ej = f[i];
    end
    #1;
    chk(inj_ready == exp_rdy, "R6 inj_ready", 64'(inj_ready), 64'(exp_rdy));
    @(negedge clk);
    chk(ej_valid == (sel != 0), "R9/R3 ej_valid", 64'(ej_valid), 64'(sel != 0));
    if (sel != 0)
      chk(ej_flit == exp_ej, (gl != 0) ? "R3 golden eject" : "R4 lowest eject",
          64'(ej_flit), 64'(exp_ej));
    chk(ch_out_valid == exp_v, "R7/R8 ch_out_valid", 64'(ch_out_valid), 64'(exp_v));
    for (int i = 0; i < NCH; i++)
      if (exp_v[i])
        chk(ch_out_flit[i*FW +: FW] == exp_f[i], ins[i] ? "R7 injected flit" : "R5 passed flit",
            64'(ch_out_flit[i*FW +: FW]), 64'(exp_f[i]));
  endtask

  initial begin
    int cnt;
    cnt = 0;
    // R1: reset with busy inputs
    ch_in_valid = '1;
    ch_in_flit = '1;
    inj_valid = 1;
    repeat (3) @(negedge clk);
    chk(ch_out_valid == 0 && ej_valid == 0 && ch_out_flit == 0 && ej_flit == 0,
        "R1 reset state", 64'({ch_out_valid, ej_valid}), 64'(0));
    rst = 0;
    for (int v = 0; v < 16; v++)
      for (int l = 0; l < 16; l++)
        for (int g = 0; g < 16; g++)
          for (int j = 0; j < 2; j++) begin
            run_case(cnt, 4'(v), 4'(l), 4'(g), j[0]);
            cnt++;
          end
    done = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule